// File: doc/BRIEF.md
# Weighted Pseudo-Random Pattern Generator

This block produces parallel test patterns for built-in self-test. The patterns' bits are not flat coin flips: each output bit is set with a probability chosen per bit. That probability can be 1/2, 1/4, 1/8 or 1/16, or the complement of any of these (1/2, 3/4, 7/8, 15/16). The source of randomness is an internal 16-bit maximal-length shift register. Each output bit owns a disjoint group of four of its stages. The bit is formed by ANDing one to four stages of its group and then optionally inverting the result. An inverted AND is the OR of the inverted stages, so both forms are covered.

A small bank of weight sets holds the per-bit controls. A test controller writes the sets while the generator is idle. It picks one set per test phase with the set-select input, then raises enable to stream one new pattern per clock. A seed can be loaded at any time. A zero seed would lock the register, so it is replaced by a fixed nonzero default.

Top module: `wpat_gen`

## Requirements
- R1: After reset the register holds 0xACE1 and every weight set is all zeros, so pattern bit i equals register stage 4i.
- R2: When enable is high and no seed load is requested, the register steps once per clock from s to {s[14:0], s[15]^s[13]^s[12]^s[10]} (polynomial x^16+x^14+x^13+x^11+1).
- R3: With enable low and no seed load, the register and the pattern do not change.
- R4: A seed load writes seed_i into the register on the next clock and takes priority over enable.
- R5: A seed load of zero writes 0xACE1 instead, and the register never holds zero.
- R6: Each weight set has three bits per output bit i at positions [3i+2:3i]: bits [3i+1:3i] are a weight code w, and pattern bit i is the AND of stages 4i through 4i+w.
- R7: Bit 3i+2 of the selected set inverts pattern bit i after the AND.
- R8: Three weight sets are held at once. The pattern follows the set named by wset_sel_i in the same cycle, and a select value of 3 reads set 0.
- R9: A weight-set write (cfg_we_i with index 0 to 2) takes effect only while enable is low. A write while enable is high leaves the set unchanged.
- R10: Over a long run, the fraction of ones in the pattern is close to 1/16 for weight code 3, 1/8 for code 2, and 15/16 for code 3 with inversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Advance the register one step per clock |
| seed_ld_i | input | 1 | Load seed_i into the register |
| seed_i | input | 16 | Seed value (zero is replaced) |
| wset_sel_i | input | 2 | Weight set used for the pattern |
| cfg_we_i | input | 1 | Write a weight set |
| cfg_idx_i | input | 2 | Weight set to write |
| cfg_data_i | input | 12 | New weight-set contents |
| pattern_o | output | 4 | Weighted pattern |

## Verification
The assertions check, on every clock edge, that:
- the register is never zero;
- it holds still when idle;
- it takes a loaded seed, or the default in place of a zero seed;
- it shifts its stages on each enabled step;
- the weight bank does not change while enable is high.

The feedback value itself, the per-bit weight and inversion encoding, and the switching between stored sets are visible only at the pattern output. The bench shows them with seeded vectors and a cycle-exact reference run. The programmed probabilities are statistical properties, so only the bench's long counted runs can show them.

// File: rtl/wpat_gen.sv
module wpat_gen #(
  parameter int                LFSR_W   = 16,
  parameter int                NSETS    = 3,
  parameter logic [LFSR_W-1:0] TAPS     = 16'hB400,
  parameter logic [LFSR_W-1:0] SEED_DEF = 16'hACE1,
  localparam int GRP   = 4,
  localparam int PAT_W = LFSR_W / GRP,
  localparam int CW    = 3 * PAT_W,
  localparam int SEL_W = (NSETS > 1) ? $clog2(NSETS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              seed_ld_i,
  input  logic [LFSR_W-1:0] seed_i,
  input  logic [SEL_W-1:0]  wset_sel_i,
  input  logic              cfg_we_i,
  input  logic [SEL_W-1:0]  cfg_idx_i,
  input  logic [CW-1:0]     cfg_data_i,
  output logic [PAT_W-1:0]  pattern_o
);

  logic [LFSR_W-1:0]          lfsr_q;
  logic [NSETS-1:0][CW-1:0]   cfg_q;
  logic [CW-1:0]              cur_cfg;
  logic                       fb;

  assign fb = ^(lfsr_q & TAPS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      lfsr_q <= SEED_DEF;
    else if (seed_ld_i)
      lfsr_q <= (seed_i == '0) ? SEED_DEF : seed_i;
    else if (en_i)
      lfsr_q <= {lfsr_q[LFSR_W-2:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cfg_q <= '0;
    else if (cfg_we_i && !en_i && (int'(cfg_idx_i) < NSETS))
      cfg_q[cfg_idx_i] <= cfg_data_i;
  end

  assign cur_cfg = (int'(wset_sel_i) < NSETS) ? cfg_q[wset_sel_i] : cfg_q[0];

  for (genvar i = 0; i < PAT_W; i++) begin : g_bit
    logic [GRP-1:0] grp;
    logic [1:0]     w;
    logic           prod;
    assign grp = lfsr_q[GRP*i +: GRP];
    assign w   = cur_cfg[3*i +: 2];
    always_comb begin
      case (w)
        2'd0:    prod = grp[0];
        2'd1:    prod = &grp[1:0];
        2'd2:    prod = &grp[2:0];
        default: prod = &grp[3:0];
      endcase
    end
    assign pattern_o[i] = prod ^ cur_cfg[3*i+2];
  end

endmodule

module wpat_gen_chk #(
  parameter int                LFSR_W   = 16,
  parameter int                CWALL    = 36,
  parameter logic [LFSR_W-1:0] SEED_DEF = 16'hACE1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_i,
  input logic              seed_ld_i,
  input logic [LFSR_W-1:0] seed_i,
  input logic [LFSR_W-1:0] lfsr_q,
  input logic [CWALL-1:0]  cfg_q
);

  p_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !seed_ld_i) |=> $stable(lfsr_q));

  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_ld_i && seed_i != '0) |=> lfsr_q == $past(seed_i));

  p_zero_seed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_ld_i && seed_i == '0) |=> lfsr_q == SEED_DEF);

  p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !seed_ld_i) |=> lfsr_q[LFSR_W-1:1] == $past(lfsr_q[LFSR_W-2:0]));

  p_cfg_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |=> $stable(cfg_q));

endmodule

bind wpat_gen wpat_gen_chk #(
  .LFSR_W(LFSR_W), .CWALL(NSETS*CW), .SEED_DEF(SEED_DEF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .seed_ld_i(seed_ld_i),
  .seed_i(seed_i), .lfsr_q(lfsr_q), .cfg_q(cfg_q)
);

// File: tb/wpat_gen_bench.sv
module wpat_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_i = 1'b0;
  logic        seed_ld_i = 1'b0;
  logic [15:0] seed_i = '0;
  logic [1:0]  wset_sel_i = '0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_idx_i = '0;
  logic [11:0] cfg_data_i = '0;
  logic [3:0]  pattern_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [15:0] ref_s;

  wpat_gen u_wpat_gen (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .seed_ld_i(seed_ld_i),
    .seed_i(seed_i), .wset_sel_i(wset_sel_i), .cfg_we_i(cfg_we_i),
    .cfg_idx_i(cfg_idx_i), .cfg_data_i(cfg_data_i), .pattern_o(pattern_o)
  );

  always #4 clk = ~clk;

  typedef struct packed {
    logic [15:0] seed;
    logic [11:0] cfg;
    logic [3:0]  exp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{16'hFFFF, 12'h000, 4'b1111},
    '{16'hFFFF, 12'h6DB, 4'b1111},
    '{16'hFFFF, 12'hFFF, 4'b0000},
    '{16'h7777, 12'h6DB, 4'b0000},
    '{16'h7777, 12'h492, 4'b1111},
    '{16'h1234, 12'h249, 4'b0010},
    '{16'h1234, 12'hA14, 4'b1001},
    '{16'h0000, 12'h000, 4'b0001}
  };

  function automatic logic [15:0] nxt(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic logic [3:0] pat(input logic [15:0] s, input logic [11:0] c);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) begin
      logic a;
      a = 1'b1;
      for (int k = 0; k < 4; k++)
        if (k <= int'(c[3*i +: 2])) a = a & s[4*i+k];
      r[i] = a ^ c[3*i+2];
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [1:0] idx, input logic [11:0] d);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_idx_i = idx; cfg_data_i = d;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic ld_seed(input logic [15:0] s);
    @(negedge clk);
    seed_ld_i = 1'b1; seed_i = s;
    @(negedge clk);
    seed_ld_i = 1'b0;
    ref_s = (s == 16'h0) ? 16'hACE1 : s;
  endtask

  task automatic run_count(input logic [11:0] c, input int n, input string req,
                           input int lo, input int hi);
    int ones;
    ones = 0;
    wr_cfg(2'd0, c);
    wset_sel_i = 2'd0;
    ld_seed(16'hACE1);
    en_i = 1'b1;
    for (int t = 0; t < n; t++) begin
      @(negedge clk);
      ref_s = nxt(ref_s);
      if (pattern_o !== pat(ref_s, c)) begin
        chk("R2 step", {28'h0, pattern_o}, {28'h0, pat(ref_s, c)});
      end
      ones += $countones(pattern_o);
    end
    en_i = 1'b0;
    checks++;
    if (ones < lo || ones > hi) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d..%0d", req, ones, lo, hi);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [3:0] held;
    #20;
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state: seed 0xACE1 with weight set 0 cleared gives 0001
    chk("R1 reset", {28'h0, pattern_o}, 32'h1);

    // table walk: R6 weight code, R7 inversion, R5 zero seed, R8 set select
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      cfg_we_i = 1'b1; cfg_idx_i = 2'(k % 3); cfg_data_i = VECS[k].cfg;
      seed_ld_i = 1'b1; seed_i = VECS[k].seed; wset_sel_i = 2'(k % 3);
      @(negedge clk);
      cfg_we_i = 1'b0; seed_ld_i = 1'b0;
      #1;
      chk($sformatf("R6/R7 vector %0d", k), {28'h0, pattern_o}, {28'h0, VECS[k].exp});
    end

    // R8: three sets held together, select switches combinationally
    wr_cfg(2'd0, 12'h000);
    wr_cfg(2'd1, 12'h249);
    wr_cfg(2'd2, 12'hA14);
    ld_seed(16'h1234);
    wset_sel_i = 2'd0; #1; chk("R8 set0", {28'h0, pattern_o}, 32'hA);
    wset_sel_i = 2'd1; #1; chk("R8 set1", {28'h0, pattern_o}, 32'h2);
    wset_sel_i = 2'd2; #1; chk("R8 set2", {28'h0, pattern_o}, 32'h9);
    wset_sel_i = 2'd3; #1; chk("R8 sel3 reads set0", {28'h0, pattern_o}, 32'hA);

    // R3: idle hold
    wset_sel_i = 2'd0;
    held = pattern_o;
    repeat (5) @(negedge clk);
    chk("R3 hold", {28'h0, pattern_o}, {28'h0, held});

    // R4: seed load wins over enable
    @(negedge clk);
    en_i = 1'b1; seed_ld_i = 1'b1; seed_i = 16'hFFFF;
    @(negedge clk);
    en_i = 1'b0; seed_ld_i = 1'b0;
    chk("R4 load priority", {28'h0, pattern_o}, 32'hF);

    // R9: write while enabled is ignored, checked after stepping
    ld_seed(16'h7777);
    @(negedge clk);
    en_i = 1'b1; cfg_we_i = 1'b1; cfg_idx_i = 2'd0; cfg_data_i = 12'hFFF;
    @(negedge clk);
    en_i = 1'b0; cfg_we_i = 1'b0;
    ref_s = nxt(ref_s);
    wset_sel_i = 2'd0; #1;
    chk("R9 write ignored", {28'h0, pattern_o}, {28'h0, pat(ref_s, 12'h000)});
    wset_sel_i = 2'd0; #1;
    chk("R9 set0 vs written", {31'h0, pattern_o == pat(ref_s, 12'hFFF)}, 32'h0);

    // R2 exact stepping and R10 weight statistics (16384 bit trials)
    run_count(12'h6DB, 4096, "R10 p=1/16", 800, 1250);
    run_count(12'h492, 4096, "R10 p=1/8", 1750, 2350);
    run_count(12'hFFF, 4096, "R10 p=15/16", 15100, 15600);
    chk("R2 final state pattern", {28'h0, pattern_o}, {28'h0, pat(ref_s, 12'hFFF)});

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule